// File: doc/BRIEF.md
# NIC Command and Status Unit

This block is the command and status front end of a network controller's host register file. The host drives every control action through one 16-bit command port. The upper five bits select an operation and the lower eleven bits carry its argument. The same port offset, when read, returns a 16-bit status word. The block decodes each command and keeps several pieces of state: the selected register window, the receive filter, the status-visibility mask, the interrupt-enable mask, and the receiver and transmitter enables. It also captures event pulses from the MAC datapath and DMA engine into sticky status bits, and it drives an interrupt request line.

The three reset commands take several cycles. Total reset, receive reset and transmit reset each hold a command-in-progress flag for `RST_CYCLES` cycles. Software must poll that flag before it issues a dependent command. Any command written while the flag is set is dropped, and a sticky error output records that it was dropped.

Top module: `nic_cmd_status`

## Requirements
- R1: A command word carries its operation in bits 15:11 and its argument in bits 10:0. Operation 1 loads the window number from argument bits 2:0, and status bits 15:13 read back that window number.
- R2: After `rst_n` is released, the window is 0, both masks are 0, the filter is 0, the receiver and transmitter are disabled, no event is latched, `irq_o` is low and `cmd_err_o` is low.
- R3: A pulse on `evt_in[i]` (i = 0..10) latches event bit i, and the bit stays latched. Status bit i reads 1 only when bit i is latched and bit i of the visibility mask is set. Operation 15 loads the visibility mask from argument bits 10:0.
- R4: Operation 13 clears every latched event bit whose position is set in the argument. If an event pulse arrives on the same clock edge as an acknowledge of that bit, the bit stays latched.
- R5: `irq_o` is the OR over all bits of (latched events AND interrupt-enable mask). `irq_o` rises in the cycle after the event edge. Operation 14 loads the interrupt-enable mask from argument bits 10:0.
- R6: Operation 16 loads `rx_filter_o` from argument bits 3:0. The bits mean: bit 0 station address, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.
- R7: Operation 4 enables the receiver and operation 3 disables it. Operation 9 enables the transmitter and operation 10 disables it.
- R8: Operation 5 (receive reset) and operation 11 (transmit reset) disable their own path. Each then holds status bit 12 and its own reset output (`rx_rst_o` or `tx_rst_o`) high for exactly `RST_CYCLES` cycles, starting in the cycle after the command.
- R9: Operation 0 (total reset) clears the window, both masks, the filter, both enables, every latched event and `cmd_err_o`. It then holds status bit 12 and both reset outputs high for `RST_CYCLES` cycles.
- R10: Any command written while status bit 12 is set has no effect and sets `cmd_err_o`. `cmd_err_o` stays set until an accepted total reset or `rst_n` clears it.
- R11: Status bit 11 follows `dma_busy_in` live, whatever the visibility mask holds. Operation codes not listed above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: operation in 15:11, argument in 10:0 |
| evt_in | input | 11 | Event pulses from the datapath, one per status bit 10:0 |
| dma_busy_in | input | 1 | Live DMA-in-progress level |
| status_o | output | 16 | Status word: window, busy, DMA busy, visible events |
| irq_o | output | 1 | Interrupt request |
| win_o | output | 3 | Selected register window |
| rx_filter_o | output | 4 | Receive filter classes |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_rst_o | output | 1 | Receive reset running |
| tx_rst_o | output | 1 | Transmit reset running |
| cmd_err_o | output | 1 | Sticky flag: a command was dropped while busy |

## Verification
An acknowledge command and a new event pulse on the same status bit can land on the same clock edge. Likewise, a command write can coincide with the last busy cycle of a reset. The bench provokes the first case directly, by acknowledging bit 4 while pulsing `evt_in[4]`. It provokes the second by writing a filter command exactly at the final busy cycle. Random traffic then mixes both kinds of collision. Each outcome is judged against a bench model written from the requirements: the event wins over the acknowledge, and a write during any busy cycle is dropped and flagged.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int CMD_W  = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = 11;
  localparam int EVT_W  = 11;
  localparam int WIN_W  = 3;
  localparam int FILT_W = 4;

  localparam logic [OP_W-1:0] OP_TOTAL_RST = 5'd0;
  localparam logic [OP_W-1:0] OP_WIN       = 5'd1;
  localparam logic [OP_W-1:0] OP_RX_DIS    = 5'd3;
  localparam logic [OP_W-1:0] OP_RX_EN     = 5'd4;
  localparam logic [OP_W-1:0] OP_RX_RST    = 5'd5;
  localparam logic [OP_W-1:0] OP_TX_EN     = 5'd9;
  localparam logic [OP_W-1:0] OP_TX_DIS    = 5'd10;
  localparam logic [OP_W-1:0] OP_TX_RST    = 5'd11;
  localparam logic [OP_W-1:0] OP_ACK       = 5'd13;
  localparam logic [OP_W-1:0] OP_IE        = 5'd14;
  localparam logic [OP_W-1:0] OP_SE        = 5'd15;
  localparam logic [OP_W-1:0] OP_FILT      = 5'd16;

  typedef struct packed {
    logic total;
    logic rx_rst;
    logic tx_rst;
    logic win;
    logic ack;
    logic ie;
    logic se;
    logic filt;
    logic rx_en;
    logic rx_dis;
    logic tx_en;
    logic tx_dis;
    logic reject;
  } nic_cmd_s;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_cmd_pkg::*;
(
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             busy,
  output nic_cmd_s         cmd,
  output logic [ARG_W-1:0] arg
);
  logic [OP_W-1:0] op;
  logic            accept;

  assign op     = cmd_data[CMD_W-1:ARG_W];
  assign arg    = cmd_data[ARG_W-1:0];
  assign accept = cmd_we & ~busy;

  always_comb begin
    cmd        = '0;
    cmd.reject = cmd_we & busy;
    if (accept) begin
      case (op)
        OP_TOTAL_RST: cmd.total  = 1'b1;
        OP_WIN:       cmd.win    = 1'b1;
        OP_RX_DIS:    cmd.rx_dis = 1'b1;
        OP_RX_EN:     cmd.rx_en  = 1'b1;
        OP_RX_RST:    cmd.rx_rst = 1'b1;
        OP_TX_EN:     cmd.tx_en  = 1'b1;
        OP_TX_DIS:    cmd.tx_dis = 1'b1;
        OP_TX_RST:    cmd.tx_rst = 1'b1;
        OP_ACK:       cmd.ack    = 1'b1;
        OP_IE:        cmd.ie     = 1'b1;
        OP_SE:        cmd.se     = 1'b1;
        OP_FILT:      cmd.filt   = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/nic_reset_seq.sv
module nic_reset_seq #(
  parameter int RST_CYCLES = 16,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic total_cmd,
  input  logic rx_cmd,
  input  logic tx_cmd,
  output logic busy,
  output logic rx_active,
  output logic tx_active
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rx_kind_q, rx_kind_d;
  logic             tx_kind_q, tx_kind_d;
  logic             load;
  logic             cnt_en;

  assign load   = total_cmd | rx_cmd | tx_cmd;
  assign busy   = (cnt_q != '0);
  assign cnt_en = load | busy;

  always_comb begin
    cnt_d     = cnt_q;
    rx_kind_d = rx_kind_q;
    tx_kind_d = tx_kind_q;
    if (load) begin
      cnt_d     = CNT_W'(RST_CYCLES);
      rx_kind_d = total_cmd | rx_cmd;
      tx_kind_d = total_cmd | tx_cmd;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rx_kind_q <= 1'b0;
      tx_kind_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q     <= cnt_d;
      rx_kind_q <= rx_kind_d;
      tx_kind_q <= tx_kind_d;
    end
  end

  assign rx_active = busy & rx_kind_q;
  assign tx_active = busy & tx_kind_q;

  AST_LOAD_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && (rx_active || tx_active))); // R8
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load); // R10
endmodule

// File: rtl/nic_evt_latch.sv
module nic_evt_latch #(
  parameter int EVT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_in,
  input  logic             ack_cmd,
  input  logic [EVT_W-1:0] ack_mask,
  input  logic             clr_all,
  output logic [EVT_W-1:0] lat_q
);
  logic [EVT_W-1:0] lat_d;
  logic [EVT_W-1:0] bit_en;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_comb begin
      bit_en[i] = clr_all | evt_in[i] | (ack_cmd & ack_mask[i]);
      if (clr_all)        lat_d[i] = 1'b0;
      else if (evt_in[i]) lat_d[i] = 1'b1;
      else                lat_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lat_q[i] <= 1'b0;
      else if (bit_en[i]) lat_q[i] <= lat_d[i];
    end
  end

  AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((lat_q & $past(evt_in)) == $past(evt_in))); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (lat_q == '0)); // R9
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_cmd_pkg::*;
#(
  parameter int EVT_W  = 11,
  parameter int WIN_W  = 3,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nic_cmd_s          cmd,
  input  logic [ARG_W-1:0]  arg,
  output logic [WIN_W-1:0]  win_q,
  output logic [FILT_W-1:0] filt_q,
  output logic [EVT_W-1:0]  ie_q,
  output logic [EVT_W-1:0]  se_q,
  output logic              rx_en_q,
  output logic              tx_en_q,
  output logic              err_q
);
  logic [WIN_W-1:0]  win_d;
  logic [FILT_W-1:0] filt_d;
  logic [EVT_W-1:0]  ie_d, se_d;
  logic              rx_en_d, tx_en_d, err_d;
  logic              win_ce, filt_ce, ie_ce, se_ce, rx_ce, tx_ce, err_ce;

  assign win_ce  = cmd.total | cmd.win;
  assign filt_ce = cmd.total | cmd.filt;
  assign ie_ce   = cmd.total | cmd.ie;
  assign se_ce   = cmd.total | cmd.se;
  assign rx_ce   = cmd.total | cmd.rx_rst | cmd.rx_en | cmd.rx_dis;
  assign tx_ce   = cmd.total | cmd.tx_rst | cmd.tx_en | cmd.tx_dis;
  assign err_ce  = cmd.total | cmd.reject;

  always_comb begin
    win_d   = cmd.total ? '0 : arg[WIN_W-1:0];
    filt_d  = cmd.total ? '0 : arg[FILT_W-1:0];
    ie_d    = cmd.total ? '0 : arg[EVT_W-1:0];
    se_d    = cmd.total ? '0 : arg[EVT_W-1:0];
    rx_en_d = cmd.rx_en;
    tx_en_d = cmd.tx_en;
    err_d   = cmd.reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      filt_q  <= '0;
      ie_q    <= '0;
      se_q    <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (win_ce)  win_q   <= win_d;
      if (filt_ce) filt_q  <= filt_d;
      if (ie_ce)   ie_q    <= ie_d;
      if (se_ce)   se_q    <= se_d;
      if (rx_ce)   rx_en_q <= rx_en_d;
      if (tx_ce)   tx_en_q <= tx_en_d;
      if (err_ce)  err_q   <= err_d;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !cmd.total) |=> err_q); // R10
  AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.win && !cmd.total) |=> $stable(win_q)); // R1
  AST_RXRST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rx_rst |=> !rx_en_q); // R8
endmodule

// File: rtl/nic_cmd_status.sv
module nic_cmd_status
  import nic_cmd_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              dma_busy_in,
  output logic [CMD_W-1:0]  status_o,
  output logic              irq_o,
  output logic [WIN_W-1:0]  win_o,
  output logic [FILT_W-1:0] rx_filter_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              cmd_err_o
);
  nic_cmd_s         cmd;
  logic [ARG_W-1:0] arg;
  logic             busy;
  logic [EVT_W-1:0] lat;
  logic [EVT_W-1:0] ie_mask, se_mask;

  nic_cmd_decode u_dec (
    .cmd_we   (cmd_we),
    .cmd_data (cmd_data),
    .busy     (busy),
    .cmd      (cmd),
    .arg      (arg)
  );

  nic_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .total_cmd (cmd.total),
    .rx_cmd    (cmd.rx_rst),
    .tx_cmd    (cmd.tx_rst),
    .busy      (busy),
    .rx_active (rx_rst_o),
    .tx_active (tx_rst_o)
  );

  nic_evt_latch #(.EVT_W(EVT_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_in),
    .ack_cmd  (cmd.ack),
    .ack_mask (arg[EVT_W-1:0]),
    .clr_all  (cmd.total),
    .lat_q    (lat)
  );

  nic_ctrl_regs #(.EVT_W(EVT_W), .WIN_W(WIN_W), .FILT_W(FILT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .arg     (arg),
    .win_q   (win_o),
    .filt_q  (rx_filter_o),
    .ie_q    (ie_mask),
    .se_q    (se_mask),
    .rx_en_q (rx_en_o),
    .tx_en_q (tx_en_o),
    .err_q   (cmd_err_o)
  );

  assign status_o = {win_o, busy, dma_busy_in, lat & se_mask};
  assign irq_o    = |(lat & ie_mask);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_mask == '0) |-> !irq_o); // R5
  AST_RESET_OUTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst_o || tx_rst_o) |-> status_o[12]); // R8
endmodule

// File: tb/tb_nic_cmd_status.sv
module tb_nic_cmd_status;
  localparam int RST_CYCLES = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [15:0] cmd_data;
  logic [10:0] evt_in;
  logic        dma_busy_in;
  logic [15:0] status_o;
  logic        irq_o;
  logic [2:0]  win_o;
  logic [3:0]  rx_filter_o;
  logic        rx_en_o, tx_en_o, rx_rst_o, tx_rst_o, cmd_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model, derived from the requirements
  int          m_cnt;
  logic [10:0] m_lat, m_ie, m_se;
  logic [2:0]  m_win;
  logic [3:0]  m_filt;
  logic        m_rxen, m_txen, m_err, m_rxk, m_txk;

  always #5 clk = ~clk;

  nic_cmd_status #(.RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .evt_in(evt_in), .dma_busy_in(dma_busy_in), .status_o(status_o),
    .irq_o(irq_o), .win_o(win_o), .rx_filter_o(rx_filter_o),
    .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_rst_o(rx_rst_o),
    .tx_rst_o(tx_rst_o), .cmd_err_o(cmd_err_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_status();
    return {m_win, (m_cnt != 0), dma_busy_in, m_lat & m_se};
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_lat = '0; m_ie = '0; m_se = '0; m_win = '0; m_filt = '0;
    m_rxen = 0; m_txen = 0; m_err = 0; m_rxk = 0; m_txk = 0;
  endtask

  task automatic model_edge(input logic we, input logic [15:0] c, input logic [10:0] ev);
    logic        busy;
    logic        load;
    logic        ack;
    logic [10:0] a;
    busy = (m_cnt != 0);
    load = 1'b0;
    ack  = 1'b0;
    a    = c[10:0];
    if (we && busy) m_err = 1'b1;
    else if (we) begin
      case (c[15:11])
        5'd0: begin
          m_win = '0; m_filt = '0; m_ie = '0; m_se = '0; m_rxen = 0; m_txen = 0;
          m_err = 0; load = 1; m_rxk = 1; m_txk = 1;
        end
        5'd1:  m_win = a[2:0];
        5'd3:  m_rxen = 0;
        5'd4:  m_rxen = 1;
        5'd5:  begin m_rxen = 0; load = 1; m_rxk = 1; m_txk = 0; end
        5'd9:  m_txen = 1;
        5'd10: m_txen = 0;
        5'd11: begin m_txen = 0; load = 1; m_rxk = 0; m_txk = 1; end
        5'd13: ack = 1;
        5'd14: m_ie = a;
        5'd15: m_se = a;
        5'd16: m_filt = a[3:0];
        default: ;
      endcase
    end
    if (we && !busy && c[15:11] == 5'd0) m_lat = '0;
    else m_lat = ev | (m_lat & ~(ack ? a : 11'd0));
    if (load) m_cnt = RST_CYCLES;
    else if (m_cnt != 0) m_cnt = m_cnt - 1;
  endtask

  task automatic compare_all();
    logic [15:0] es;
    es = exp_status();
    check("R1 window", {29'd0, status_o[15:13]}, {29'd0, es[15:13]});
    check("R1 win_o", {29'd0, win_o}, {29'd0, m_win});
    check("R8 busy bit", {31'd0, status_o[12]}, {31'd0, es[12]});
    check("R11 dma bit", {31'd0, status_o[11]}, {31'd0, es[11]});
    check("R3 events", {21'd0, status_o[10:0]}, {21'd0, es[10:0]});
    check("R5 irq", {31'd0, irq_o}, {31'd0, |(m_lat & m_ie)});
    check("R6 filter", {28'd0, rx_filter_o}, {28'd0, m_filt});
    check("R7 enables", {30'd0, rx_en_o, tx_en_o}, {30'd0, m_rxen, m_txen});
    check("R8 reset outs", {30'd0, rx_rst_o, tx_rst_o},
          {30'd0, m_rxk && (m_cnt != 0), m_txk && (m_cnt != 0)});
    check("R10 err", {31'd0, cmd_err_o}, {31'd0, m_err});
  endtask

  task automatic step(input logic we, input logic [15:0] c, input logic [10:0] ev);
    cmd_we = we; cmd_data = c; evt_in = ev;
    @(posedge clk);
    model_edge(we, c, ev);
    @(negedge clk);
    cmd_we = 1'b0; evt_in = '0;
    compare_all();
  endtask

  function automatic logic [15:0] mk(input int op, input int a);
    return {op[4:0], a[10:0]};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 11'h0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int busy_len;
    int seed;
    int ops[13];
    seed = $urandom(32'h5eed_1234);
    ops = '{0, 1, 3, 4, 5, 9, 10, 11, 13, 14, 15, 16, 7};
    rst_n = 1'b0; cmd_we = 1'b0; cmd_data = '0; evt_in = '0; dma_busy_in = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state at the ports
    check("R2 status", {16'd0, status_o}, 32'd0);
    check("R2 irq", {31'd0, irq_o}, 32'd0);
    check("R2 enables/err", {29'd0, rx_en_o, tx_en_o, cmd_err_o}, 32'd0);
    check("R2 filter/win", {25'd0, rx_filter_o, win_o}, 32'd0);

    // R1: window select uses only argument bits 2:0
    step(1'b1, mk(1, 11'h7FD), 11'h0);
    check("R1 window 5", {29'd0, status_o[15:13]}, 32'd5);

    // R3: event hidden until visibility mask set
    step(1'b0, 16'h0, 11'h010);
    check("R3 hidden", {21'd0, status_o[10:0]}, 32'd0);
    step(1'b1, mk(15, 11'h7FF), 11'h0);
    check("R3 visible", {21'd0, status_o[10:0]}, 32'h010);

    // R5: interrupt follows enable
    step(1'b1, mk(14, 11'h010), 11'h0);
    check("R5 irq high", {31'd0, irq_o}, 32'd1);

    // R4: ack and event on the same edge; event wins
    step(1'b1, mk(13, 11'h010), 11'h010);
    check("R4 event wins", {31'd0, status_o[4]}, 32'd1);
    step(1'b1, mk(13, 11'h010), 11'h0);
    check("R4 acked", {31'd0, status_o[4]}, 32'd0);

    // R6, R7, R11
    step(1'b1, mk(16, 11'h00B), 11'h0);
    step(1'b1, mk(4, 0), 11'h0);
    step(1'b1, mk(9, 0), 11'h0);
    check("R7 both on", {30'd0, rx_en_o, tx_en_o}, 32'd3);
    dma_busy_in = 1'b1;
    step(1'b1, mk(7, 11'h7FF), 11'h0);
    check("R11 dma live", {31'd0, status_o[11]}, 32'd1);
    dma_busy_in = 1'b0;

    // R8: receive reset busy length
    step(1'b1, mk(5, 0), 11'h0);
    busy_len = 0;
    while (status_o[12] && busy_len < 100) begin
      busy_len++;
      if (busy_len == RST_CYCLES) step(1'b1, mk(16, 11'h005), 11'h0); // R10 last busy cycle
      else step(1'b0, 16'h0, 11'h0);
    end
    check("R8 busy length", busy_len, RST_CYCLES);
    check("R10 dropped filter", {28'd0, rx_filter_o}, 32'h00B);
    check("R10 err set", {31'd0, cmd_err_o}, 32'd1);

    // R9: total reset clears everything
    step(1'b0, 16'h0, 11'h044);
    step(1'b1, mk(0, 0), 11'h0);
    idle(RST_CYCLES);
    check("R9 cleared", {16'd0, status_o}, 32'd0);
    check("R9 err clear", {31'd0, cmd_err_o}, 32'd0);

    // random traffic mixed with collisions
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic we;
      logic [10:0] ev;
      op = ops[$urandom_range(0, 12)];
      if (op == 0 || op == 5 || op == 11) op = ($urandom_range(0, 3) == 0) ? op : 13;
      we = ($urandom_range(0, 2) == 0);
      ev = ($urandom_range(0, 3) == 0) ? 11'(1 << $urandom_range(0, 10)) : 11'h0;
      dma_busy_in = $urandom_range(0, 1) == 1;
      step(we, mk(op, int'($urandom_range(0, 2047))), ev);
    end

    done = 1'b1;
    finish_run();
  end
endmodule